// File: doc/BRIEF.md
# UART Transmit Framer with Address Tagging

This block is the transmit half of a UART, together with its line control register. Software sets the word length, the parity mode and a nine-bit multiprocessor mode through a 32-bit configuration write port. A data-write strobe hands the block one character. The block then shifts a serial frame out on the TX line, one bit per baud tick. The baud tick is an input, because the baud generator lies outside this block.

In nine-bit mode the bit after the data bits becomes a tag instead of a parity bit. A tag of 1 marks the character as an address and a tag of 0 marks it as data. The address marking comes from a one-shot flag in the register. The flag clears itself when a character is accepted, so only the next character after software sets it is sent as an address.

The block takes a snapshot of the configuration when it accepts a character. Register writes made while a frame is on the line therefore change only the frames that follow.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset, tx_o is 1, busy_o is 0, overrun_o is 0 and cfg_rdata_o reads 0.
- R2: The register is read back on cfg_rdata_o with this layout: bit 9 enables nine-bit mode, bit 8 is the address flag, bit 7 is stick parity, bits 6:5 are the word length, bit 2 selects even parity and bit 1 enables parity. Every other bit (31:10, 4, 3 and 0) always reads 0, so writing all ones reads back 0x3E6.
- R3: The word-length codes 00, 01, 10 and 11 give 5, 6, 7 and 8 data bits. A frame is a start bit of 0, then the data bits LSB first, then the optional parity or tag bit, then a stop bit of 1.
- R4: When parity is disabled and nine-bit mode is off, no extra bit is sent. When parity is enabled and stick parity is off, the extra bit gives even parity over the data bits if bit 2 is 1, and odd parity if bit 2 is 0.
- R5: When parity is enabled and stick parity is on, the extra bit is 1 when bit 2 is 0 and 0 when bit 2 is 1.
- R6: When nine-bit mode is on, a tag bit is always sent in the parity position, whatever the parity settings are. The tag is 1 for an address and 0 for data.
- R7: An accepted data write sends the current address flag as the tag and then clears the flag, so the following character goes out as data. When nine-bit mode is off, the flag does not change the frame. If a configuration write arrives in the same cycle as an accepted data write, the configuration write sets the flag.
- R8: A configuration write made while a frame is being sent leaves that frame unchanged. The next accepted character uses the new settings.
- R9: busy_o and a start bit on tx_o appear in the cycle after an accepted data write. Each baud tick moves to the next bit. busy_o falls, and tx_o returns to its idle high level, on the tick that ends the stop bit. tx_o changes only on a baud tick or when a frame starts.
- R10: A data write while busy_o is 1 is ignored. The frame in flight continues unchanged, and overrun_o pulses high for one cycle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration register readback |
| data_we_i | input | 1 | Character write strobe |
| data_i | input | 8 | Character to transmit |
| baud_tick_i | input | 1 | One-cycle pulse that advances the frame by one bit |
| tx_o | output | 1 | Serial output, high when idle |
| busy_o | output | 1 | High while a frame is being sent |
| overrun_o | output | 1 | One-cycle pulse for an ignored data write |

## Verification
Every result is registered one stage after its cause. The readback reflects a configuration write in the next cycle. busy_o, the start bit and the flag clearing follow an accepted data write by one cycle. Each bit change follows its baud tick by one cycle, and overrun_o follows the rejected write by one cycle. Inputs are driven on the falling edge and held for exactly one rising edge, and every output is sampled on the falling edge that follows. Each check therefore lands half a cycle after the rising edge that should have produced the result. The bench expects each frame bit in turn, and the tick that ends the stop bit is followed by checks that busy_o is 0 and tx_o is 1.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int MAX_DATA_W = 8;
  localparam int MIN_DATA_W = 5;
  localparam int FRAME_W    = MAX_DATA_W + 3;
  localparam int CNT_W      = $clog2(FRAME_W + 1);

  // register bit positions
  localparam int B_NINE  = 9;
  localparam int B_ADDR  = 8;
  localparam int B_STICK = 7;
  localparam int B_WLEN  = 5;
  localparam int B_EPS   = 2;
  localparam int B_PEN   = 1;

  typedef struct packed {
    logic       nine;
    logic       addr;
    logic       stick;
    logic [1:0] wlen;
    logic       eps;
    logic       pen;
  } lcr_t;

  function automatic logic [31:0] lcr_pack(lcr_t c);
    logic [31:0] r;
    r = '0;
    r[B_NINE]            = c.nine;
    r[B_ADDR]            = c.addr;
    r[B_STICK]           = c.stick;
    r[B_WLEN+1:B_WLEN]   = c.wlen;
    r[B_EPS]             = c.eps;
    r[B_PEN]             = c.pen;
    return r;
  endfunction
endpackage

// File: rtl/uart_lcr_reg.sv
module uart_lcr_reg
  import uart_tx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [31:0] cfg_wdata_i,
  input  logic        start_i,
  output lcr_t        lcr_o
);
  lcr_t lcr_q;
  logic unused_wbits;
  assign unused_wbits = ^{cfg_wdata_i[31:10], cfg_wdata_i[4:3], cfg_wdata_i[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcr_q <= '0;
    end else if (cfg_we_i) begin
      lcr_q.nine  <= cfg_wdata_i[B_NINE];
      lcr_q.addr  <= cfg_wdata_i[B_ADDR];
      lcr_q.stick <= cfg_wdata_i[B_STICK];
      lcr_q.wlen  <= cfg_wdata_i[B_WLEN+1:B_WLEN];
      lcr_q.eps   <= cfg_wdata_i[B_EPS];
      lcr_q.pen   <= cfg_wdata_i[B_PEN];
    end else if (start_i) begin
      lcr_q.addr  <= 1'b0;  // one-shot: consumed by the accepted character
    end
  end

  assign lcr_o = lcr_q;
endmodule

// File: rtl/uart_frame_build.sv
module uart_frame_build
  import uart_tx_pkg::*;
(
  input  lcr_t                  lcr_i,
  input  logic [MAX_DATA_W-1:0] data_i,
  output logic [FRAME_W-1:0]    frame_o,
  output logic [CNT_W-1:0]      len_o
);
  int                    nd;
  logic                  extra;
  logic                  xbit;
  logic [MAX_DATA_W-1:0] masked;

  always_comb begin
    nd      = MIN_DATA_W + int'(lcr_i.wlen);
    extra   = lcr_i.nine | lcr_i.pen;
    masked  = '0;
    frame_o = '1;
    frame_o[0] = 1'b0;
    for (int i = 0; i < MAX_DATA_W; i++) begin
      if (i < nd) begin
        masked[i]    = data_i[i];
        frame_o[i+1] = data_i[i];
      end
    end
    if (lcr_i.nine)       xbit = lcr_i.addr;
    else if (lcr_i.stick) xbit = ~lcr_i.eps;
    else                  xbit = (^masked) ^ ~lcr_i.eps;
    if (extra) frame_o[nd+1] = xbit;
    len_o = CNT_W'(nd + 2 + int'(extra));
  end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               data_we_i,
  input  logic               baud_tick_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   len_i,
  output logic               tx_o,
  output logic               busy_o,
  output logic               overrun_o
);
  logic [FRAME_W-1:0] frame_q;
  logic [CNT_W-1:0]   left_q;
  logic               busy_q;
  logic               ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '1;
      left_q  <= '0;
      busy_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      ovr_q <= data_we_i & busy_q;
      if (!busy_q) begin
        if (data_we_i) begin
          frame_q <= frame_i;  // snapshot of config and data
          left_q  <= len_i;
          busy_q  <= 1'b1;
        end
      end else if (baud_tick_i) begin
        if (left_q == CNT_W'(1)) begin
          frame_q <= '1;
          left_q  <= '0;
          busy_q  <= 1'b0;
        end else begin
          frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
          left_q  <= left_q - CNT_W'(1);
        end
      end
    end
  end

  assign tx_o      = frame_q[0];
  assign busy_o    = busy_q;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [31:0] cfg_wdata_i,
  output logic [31:0] cfg_rdata_o,
  input  logic        data_we_i,
  input  logic [7:0]  data_i,
  input  logic        baud_tick_i,
  output logic        tx_o,
  output logic        busy_o,
  output logic        overrun_o
);
  lcr_t               lcr;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   len;
  logic               start;

  assign start = data_we_i & ~busy_o;

  uart_lcr_reg u_lcr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wdata_i),
    .start_i     (start),
    .lcr_o       (lcr)
  );

  uart_frame_build u_build (
    .lcr_i   (lcr),
    .data_i  (data_i),
    .frame_o (frame),
    .len_o   (len)
  );

  uart_tx_shift u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .data_we_i   (data_we_i),
    .baud_tick_i (baud_tick_i),
    .frame_i     (frame),
    .len_i       (len),
    .tx_o        (tx_o),
    .busy_o      (busy_o),
    .overrun_o   (overrun_o)
  );

  assign cfg_rdata_o = lcr_pack(lcr);
endmodule

// File: rtl/uart_tx_framer_chk.sv
module uart_tx_framer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_we_i,
  input logic [31:0] cfg_rdata_o,
  input logic        data_we_i,
  input logic        baud_tick_i,
  input logic        tx_o,
  input logic        busy_o,
  input logic        overrun_o
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[31:10] == '0) && (cfg_rdata_o[4:3] == '0) && !cfg_rdata_o[0]);

  // R9
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o);

  // R9
  start_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_i && !busy_o |=> busy_o && !tx_o);

  // R9
  hold_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !baud_tick_i |=> $stable(tx_o) && busy_o);

  // R10
  overrun_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_i && busy_o |=> overrun_o);

  // R10
  overrun_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(data_we_i && busy_o) |=> !overrun_o);

  // R7
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_i && !busy_o && !cfg_we_i |=> !cfg_rdata_o[8]);
endmodule

bind uart_tx_framer uart_tx_framer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_rdata_o (cfg_rdata_o),
  .data_we_i   (data_we_i),
  .baud_tick_i (baud_tick_i),
  .tx_o        (tx_o),
  .busy_o      (busy_o),
  .overrun_o   (overrun_o)
);

// File: tb/uart_tx_framer_tb.sv
module uart_tx_framer_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        data_we_i = 1'b0;
  logic [7:0]  data_i = '0;
  logic        baud_tick_i = 1'b0;
  logic        tx_o, busy_o, overrun_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  uart_tx_framer u_dut (.*);

  // {cfg[9:0], data, frame length, has extra bit, extra bit value}
  localparam int NV = 11;
  localparam logic [23:0] VEC [NV] = '{
    {10'h060, 8'hA5, 4'd10, 1'b0, 1'b0},  // R3 8 bits, no parity
    {10'h062, 8'hA5, 4'd11, 1'b1, 1'b1},  // R4 odd
    {10'h066, 8'hA5, 4'd11, 1'b1, 1'b0},  // R4 even
    {10'h002, 8'hFF, 4'd8,  1'b1, 1'b0},  // R3 5 bits, odd
    {10'h046, 8'h81, 4'd10, 1'b1, 1'b1},  // R3 7 bits, even
    {10'h0A2, 8'h3C, 4'd9,  1'b1, 1'b1},  // R5 stick, eps 0
    {10'h0A6, 8'h00, 4'd9,  1'b1, 1'b0},  // R5 stick, eps 1
    {10'h260, 8'h55, 4'd11, 1'b1, 1'b0},  // R6 data tag
    {10'h360, 8'h12, 4'd11, 1'b1, 1'b1},  // R6 address tag
    {10'h262, 8'h0F, 4'd11, 1'b1, 1'b0},  // R6 tag overrides parity
    {10'h160, 8'h0F, 4'd10, 1'b0, 1'b0}   // R7 flag ignored without nine-bit
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [31:0] v);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wdata_i = v;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk_i);
    baud_tick_i = 1'b1;
    @(negedge clk_i);
    baud_tick_i = 1'b0;
  endtask

  // op: 0 none, 1 config write mid-frame, 2 rejected data write mid-frame
  task automatic send(input logic [7:0] d, input int n, input logic hasx,
                      input logic xval, input int op, input logic [31:0] mid);
    int nd;
    logic exp;
    nd = n - 2 - int'(hasx);
    @(negedge clk_i);
    data_we_i = 1'b1; data_i = d;
    @(negedge clk_i);
    data_we_i = 1'b0;
    chk({31'd0, busy_o}, 32'd1, "R9 busy after write");
    chk({31'd0, tx_o}, 32'd0, "R9 start bit");
    for (int i = 1; i < n; i++) begin
      if (i == 3 && op == 1) write_cfg(mid);
      if (i == 3 && op == 2) begin
        @(negedge clk_i);
        data_we_i = 1'b1; data_i = ~d;
        @(negedge clk_i);
        data_we_i = 1'b0;
        chk({31'd0, overrun_o}, 32'd1, "R10 overrun pulse");
        @(negedge clk_i);
        chk({31'd0, overrun_o}, 32'd0, "R10 overrun one cycle");
      end
      tick();
      if (i <= nd) exp = d[i-1];
      else if (hasx && i == nd + 1) exp = xval;
      else exp = 1'b1;
      chk({31'd0, tx_o}, {31'd0, exp}, (i <= nd) ? "R3 data bit" : "R4 R5 R6 extra/stop bit");
    end
    tick();
    chk({31'd0, busy_o}, 32'd0, "R9 busy falls after stop");
    chk({31'd0, tx_o}, 32'd1, "R9 idle high");
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #35;
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({31'd0, tx_o}, 32'd1, "R1 tx idle");
    chk({31'd0, busy_o}, 32'd0, "R1 busy low");
    chk({31'd0, overrun_o}, 32'd0, "R1 overrun low");
    chk(cfg_rdata_o, 32'd0, "R1 register zero");

    write_cfg(32'hFFFF_FFFF);
    chk(cfg_rdata_o, 32'h0000_03E6, "R2 reserved bits read 0");
    write_cfg(32'h0000_0040);
    chk(cfg_rdata_o, 32'h0000_0040, "R2 word length field");

    for (int v = 0; v < NV; v++) begin
      write_cfg({22'd0, VEC[v][23:14]});
      send(VEC[v][13:6], int'(VEC[v][5:2]), VEC[v][1], VEC[v][0], 0, 32'd0);
    end
    chk({31'd0, cfg_rdata_o[8]}, 32'd0, "R7 flag cleared after write");

    // R7: one-shot address, following character is data
    write_cfg(32'h360);
    chk({31'd0, cfg_rdata_o[8]}, 32'd1, "R7 flag set");
    send(8'hC3, 11, 1'b1, 1'b1, 0, 32'd0);
    chk({31'd0, cfg_rdata_o[8]}, 32'd0, "R7 flag self-clears");
    send(8'hC3, 11, 1'b1, 1'b0, 0, 32'd0);

    // R8: mid-frame config change applies to the next frame only
    write_cfg(32'h060);
    send(8'hFF, 10, 1'b0, 1'b0, 1, 32'h000);
    chk(cfg_rdata_o, 32'h0, "R8 new value visible");
    send(8'h1F, 7, 1'b0, 1'b0, 0, 32'd0);

    // R10: rejected write leaves frame intact
    send(8'h0A, 7, 1'b0, 1'b0, 2, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule